// File: doc/BRIEF.md
# Command Stream Method Expander

This block sits between a command-word fetcher and the engines of a graphics or compute front end. It takes a stream of 32-bit command words on a valid/ready input. Each header word names an addressing mode, a subchannel and a starting method address in 32-bit register words. Most modes also carry a count of the data words that follow. One mode instead carries a short data value inside the header itself. The block turns each data word into one method write, a triple of (subchannel, method address, data), and presents it on a valid/ready output.

The address advances in one of three ways. In the stepping mode it moves by one word per data word. In the fixed mode it stays put. In the step-after-first mode the first word goes to the header address and every later word goes to the address one above it. The value-in-header mode produces exactly one write and is followed by no data words. A header whose count is zero produces nothing. A header with an unrecognised mode code sets an error flag that stays set, and the word is dropped. In both of those cases the next word is read as a new header. When the output is not accepted, the input is held off so that no data word is lost or repeated.

Top module: `push_method_decoder`

## Requirements
- R1: A header word is decoded as mode in bits [31:29], count or immediate value in bits [28:16], subchannel in bits [15:13] and method address (in 32-bit words) in bits [11:0]. Bit 12 is ignored. Mode codes: 1 = stepping, 3 = fixed, 4 = value-in-header, 5 = step-after-first.
- R2: In stepping mode, data word i (from 0) of a header with address A is written to method (A + i) modulo 4096.
- R3: In fixed mode, every data word of the header is written to method A.
- R4: In step-after-first mode, data word 0 is written to method A and every later data word to (A + 1) modulo 4096.
- R5: A value-in-header word gives exactly one write to its address, with data equal to bits [28:16] zero-extended to 32 bits. The next word is taken as a header.
- R6: A header with count zero in modes 1, 3 or 5 gives no write, and the next word is taken as a header.
- R7: A header with mode 0, 2, 6 or 7 gives no write and sets `err_flag`, and the next word is taken as a header. `err_flag` stays set until reset.
- R8: Every write carries the subchannel field of the header it came from.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields hold steady. Every data word comes out exactly once and in order.
- R10: After reset, `out_valid` and `err_flag` are low, `in_ready` is high, and the first word is taken as a header.
- R11: A write appears on the output (`out_valid` high) in the cycle after the word that produced it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block accepts the command word this cycle |
| in_word | input | 32 | Command word (header or data) |
| out_valid | output | 1 | Method write present |
| out_ready | input | 1 | Downstream accepts the method write |
| out_subch | output | 3 | Subchannel of the write |
| out_addr | output | 12 | Method address in 32-bit words |
| out_data | output | 32 | Data of the write |
| err_flag | output | 1 | Sticky flag for an unrecognised mode |

## Verification
The three counted modes are each driven with multi-word bursts, so the address sequences A,A+1,A+2, A,A,A and A,A+1,A+1 tell the three stepping rules apart. A stepping burst that starts near the top of the address space shows the wrap. A value-in-header word, a zero-count header and an unknown-mode word are each followed straight away by another header. The resulting writes show that each of those words was dropped or expanded correctly and did not swallow the next word. A long burst with a pseudo-random `out_ready` pattern checks that stalls neither lose nor repeat a data word.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_STEP  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_FIXED = 3'd3;
  localparam logic [MODE_W-1:0] MODE_IMM   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_ONCE  = 3'd5;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return (m == MODE_STEP) || (m == MODE_FIXED) || (m == MODE_IMM) || (m == MODE_ONCE);
  endfunction

  // decides whether the address moves after the current data word
  function automatic logic addr_bumps(input logic [MODE_W-1:0] m, input logic first);
    return (m == MODE_STEP) || ((m == MODE_ONCE) && first);
  endfunction

endpackage

// File: rtl/pmd_hdr_decode.sv
module pmd_hdr_decode
  import pmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int SUBCH_W = 3,
  parameter int CNT_W   = 13
) (
  input  logic [DATA_W-1:0]  word,
  output logic [MODE_W-1:0]  mode,
  output logic [CNT_W-1:0]   cnt,
  output logic [SUBCH_W-1:0] subch,
  output logic [ADDR_W-1:0]  addr,
  output logic               known,
  output logic               is_imm
);
  localparam int SUBCH_LSB = ADDR_W + 1;
  localparam int CNT_LSB   = SUBCH_LSB + SUBCH_W;
  localparam int MODE_LSB  = CNT_LSB + CNT_W;

  always_comb begin
    mode   = word[MODE_LSB +: MODE_W];
    cnt    = word[CNT_LSB +: CNT_W];
    subch  = word[SUBCH_LSB +: SUBCH_W];
    addr   = word[0 +: ADDR_W];
    known  = mode_known(mode);
    is_imm = (mode == MODE_IMM);
  end
endmodule

// File: rtl/pmd_burst_seq.sv
module pmd_burst_seq
  import pmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int SUBCH_W = 3,
  parameter int CNT_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [DATA_W-1:0]  word,
  input  logic [MODE_W-1:0]  h_mode,
  input  logic [CNT_W-1:0]   h_cnt,
  input  logic [SUBCH_W-1:0] h_subch,
  input  logic [ADDR_W-1:0]  h_addr,
  input  logic               h_known,
  input  logic               h_imm,
  output logic               hdr_fire,
  output logic               dat_fire,
  output logic [CNT_W-1:0]   burst_left,
  output logic               emit,
  output logic [SUBCH_W-1:0] emit_subch,
  output logic [ADDR_W-1:0]  emit_addr,
  output logic [DATA_W-1:0]  emit_data,
  output logic               err_flag
);
  logic               busy;
  logic [MODE_W-1:0]  cur_mode;
  logic [SUBCH_W-1:0] cur_subch;
  logic [ADDR_W-1:0]  cur_addr;
  logic               first;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic bump);
    return bump ? a + ADDR_W'(1) : a;
  endfunction

  always_comb begin
    busy       = (burst_left != '0);
    hdr_fire   = fire && !busy;
    dat_fire   = fire && busy;
    emit       = dat_fire || (hdr_fire && h_imm);
    emit_subch = busy ? cur_subch : h_subch;
    emit_addr  = busy ? cur_addr : h_addr;
    emit_data  = busy ? word : {{(DATA_W-CNT_W){1'b0}}, h_cnt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_left <= '0;
      cur_mode   <= '0;
      cur_subch  <= '0;
      cur_addr   <= '0;
      first      <= 1'b0;
      err_flag   <= 1'b0;
    end else if (hdr_fire) begin
      if (!h_known) begin
        err_flag <= 1'b1;
      end else if (!h_imm) begin
        burst_left <= h_cnt;
        cur_mode   <= h_mode;
        cur_subch  <= h_subch;
        cur_addr   <= h_addr;
        first      <= 1'b1;
      end
    end else if (dat_fire) begin
      burst_left <= burst_left - CNT_W'(1);
      cur_addr   <= step_addr(cur_addr, addr_bumps(cur_mode, first));
      first      <= 1'b0;
    end
  end
endmodule

// File: rtl/pmd_out_stage.sv
module pmd_out_stage #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int SUBCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SUBCH_W-1:0] l_subch,
  input  logic [ADDR_W-1:0]  l_addr,
  input  logic [DATA_W-1:0]  l_data,
  input  logic               out_ready,
  output logic               can_take,
  output logic               out_valid,
  output logic [SUBCH_W-1:0] out_subch,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [DATA_W-1:0]  out_data
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_subch <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_subch <= l_subch;
      out_addr  <= l_addr;
      out_data  <= l_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/push_method_decoder.sv
module push_method_decoder
  import pmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int SUBCH_W = 3,
  parameter int CNT_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SUBCH_W-1:0] out_subch,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [DATA_W-1:0]  out_data,
  output logic               err_flag
);
  logic [MODE_W-1:0]  h_mode;
  logic [CNT_W-1:0]   h_cnt;
  logic [SUBCH_W-1:0] h_subch;
  logic [ADDR_W-1:0]  h_addr;
  logic               h_known, h_imm;
  logic               fire, hdr_fire, dat_fire, emit;
  logic [CNT_W-1:0]   burst_left;
  logic [SUBCH_W-1:0] emit_subch;
  logic [ADDR_W-1:0]  emit_addr;
  logic [DATA_W-1:0]  emit_data;
  logic               can_take;

  assign in_ready = can_take;
  assign fire     = in_valid && can_take;

  pmd_hdr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)) dec_i (
    .word(in_word), .mode(h_mode), .cnt(h_cnt), .subch(h_subch), .addr(h_addr),
    .known(h_known), .is_imm(h_imm)
  );

  pmd_burst_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .word(in_word),
    .h_mode(h_mode), .h_cnt(h_cnt), .h_subch(h_subch), .h_addr(h_addr),
    .h_known(h_known), .h_imm(h_imm),
    .hdr_fire(hdr_fire), .dat_fire(dat_fire), .burst_left(burst_left),
    .emit(emit), .emit_subch(emit_subch), .emit_addr(emit_addr), .emit_data(emit_data),
    .err_flag(err_flag)
  );

  pmd_out_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUBCH_W(SUBCH_W)) out_i (
    .clk(clk), .rst_n(rst_n), .load(emit),
    .l_subch(emit_subch), .l_addr(emit_addr), .l_data(emit_data),
    .out_ready(out_ready), .can_take(can_take), .out_valid(out_valid),
    .out_subch(out_subch), .out_addr(out_addr), .out_data(out_data)
  );
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int SUBCH_W = 3,
  parameter int CNT_W   = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SUBCH_W-1:0] out_subch,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [DATA_W-1:0]  out_data,
  input logic               err_flag,
  input logic               dat_fire,
  input logic               emit,
  input logic [CNT_W-1:0]   burst_left
);
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);  // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_subch)));  // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);  // R7

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fire |=> (burst_left == $past(burst_left) - CNT_W'(1)));  // R9

  AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> out_valid);  // R11
endmodule

bind push_method_decoder pmd_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_subch(out_subch), .out_addr(out_addr),
  .out_data(out_data), .err_flag(err_flag), .dat_fire(dat_fire),
  .emit(emit), .burst_left(burst_left)
);

// File: tb/push_method_decoder_tb_top.sv
module push_method_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_subch;
  logic [11:0] out_addr;
  logic [31:0] out_data;
  logic        err_flag;

  always #10 clk = ~clk;

  push_method_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_subch(out_subch),
    .out_addr(out_addr), .out_data(out_data), .err_flag(err_flag)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          cap_n = 0;
  logic [2:0]  cap_sub  [64];
  logic [11:0] cap_addr [64];
  logic [31:0] cap_data [64];
  logic        bp_on = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic        hold_v = 1'b0;
  logic [2:0]  h_sub;
  logic [11:0] h_addr;
  logic [31:0] h_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [2:0] m, input logic [12:0] c,
                                      input logic [2:0] s, input logic [11:0] a);
    return {m, c, s, 1'b0, a};
  endfunction

  // expected address of data word i, written from the requirement text
  function automatic logic [11:0] exp_addr(input logic [2:0] m, input logic [11:0] base, input int i);
    logic [11:0] off;
    off = (m == 3'd1) ? 12'(i) : (m == 3'd5 && i > 0) ? 12'd1 : 12'd0;
    return base + off;
  endfunction

  // downstream model: choose out_ready, record handshakes, watch held values
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b1;
      hold_v = 1'b0;
    end else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (hold_v)
        chk(out_valid && out_data == h_data && out_addr == h_addr && out_subch == h_sub,
            "R9 held", out_data, h_data);
      out_ready = bp_on ? lfsr[0] : 1'b1;
      hold_v = out_valid && !out_ready;
      h_sub = out_subch; h_addr = out_addr; h_data = out_data;
      if (out_valid && out_ready && cap_n < 64) begin
        cap_sub[cap_n]  = out_subch;
        cap_addr[cap_n] = out_addr;
        cap_data[cap_n] = out_data;
        cap_n++;
      end
    end
  end

  task automatic push(input logic [31:0] w);
    @(negedge clk); #2;
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic stop_and_drain();
    @(negedge clk); #2;
    in_valid = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic clear_cap();
    @(negedge clk); #2;
    cap_n = 0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R10 out_valid", 32'(out_valid), 32'd0);
    chk(err_flag == 1'b0, "R10 err_flag", 32'(err_flag), 32'd0);
    chk(in_ready == 1'b1, "R10 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_burst(input logic [2:0] m, input logic [2:0] s, input logic [11:0] base,
                         input int n, input logic [31:0] seed, input string req);
    clear_cap();
    push(hdr(m, 13'(n), s, base));
    for (int i = 0; i < n; i++) push(seed + 32'(i) * 32'h01010101);
    stop_and_drain();
    chk(cap_n == n, req, 32'(cap_n), 32'(n));
    for (int i = 0; i < n && i < cap_n; i++) begin
      chk(cap_sub[i] == s, "R8 subchannel", 32'(cap_sub[i]), 32'(s));
      chk(cap_addr[i] == exp_addr(m, base, i), req, 32'(cap_addr[i]), 32'(exp_addr(m, base, i)));
      chk(cap_data[i] == seed + 32'(i) * 32'h01010101, req, cap_data[i], seed + 32'(i) * 32'h01010101);
    end
  endtask

  task automatic t_imm();
    clear_cap();
    push(hdr(3'd4, 13'h1ABC, 3'd6, 12'h2A0));
    push(hdr(3'd1, 13'd1, 3'd1, 12'h010));
    push(32'hDEADBEEF);
    stop_and_drain();
    chk(cap_n == 2, "R5 write count", 32'(cap_n), 32'd2);
    chk(cap_addr[0] == 12'h2A0 && cap_sub[0] == 3'd6, "R5 address", 32'(cap_addr[0]), 32'h2A0);
    chk(cap_data[0] == 32'h00001ABC, "R5 data", cap_data[0], 32'h00001ABC);
    chk(cap_addr[1] == 12'h010 && cap_data[1] == 32'hDEADBEEF, "R5 next header", cap_data[1], 32'hDEADBEEF);
  endtask

  task automatic t_zero();
    clear_cap();
    push(hdr(3'd1, 13'd0, 3'd2, 12'h050));
    push(hdr(3'd3, 13'd2, 3'd3, 12'h060));
    push(32'h11110000);
    push(32'h22220000);
    stop_and_drain();
    chk(cap_n == 2, "R6 write count", 32'(cap_n), 32'd2);
    chk(cap_addr[0] == 12'h060 && cap_addr[1] == 12'h060, "R6 address", 32'(cap_addr[1]), 32'h060);
    chk(cap_data[0] == 32'h11110000, "R6 data", cap_data[0], 32'h11110000);
  endtask

  task automatic t_bad();
    chk(err_flag == 1'b0, "R7 clear before", 32'(err_flag), 32'd0);
    clear_cap();
    push(hdr(3'd2, 13'd1, 3'd0, 12'h070));
    push(hdr(3'd7, 13'd3, 3'd0, 12'h072));
    push(hdr(3'd4, 13'h0055, 3'd4, 12'h071));
    stop_and_drain();
    chk(err_flag == 1'b1, "R7 flag set", 32'(err_flag), 32'd1);
    chk(cap_n == 1, "R7 write count", 32'(cap_n), 32'd1);
    chk(cap_addr[0] == 12'h071 && cap_data[0] == 32'h55, "R7 next header", cap_data[0], 32'h55);
  endtask

  task automatic t_latency();
    clear_cap();
    chk(out_valid == 1'b0, "R11 idle before", 32'(out_valid), 32'd0);
    in_valid = 1'b1;
    in_word  = hdr(3'd4, 13'h0123, 3'd5, 12'h0AB);
    @(negedge clk); #2;
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_data == 32'h123 && out_addr == 12'h0AB,
        "R11 next cycle", out_data, 32'h123);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_latency();
    t_burst(3'd1, 3'd2, 12'h100, 3, 32'hA0000000, "R1/R2 stepping");
    t_burst(3'd3, 3'd5, 12'h200, 4, 32'hB0000000, "R3 fixed");
    t_burst(3'd5, 3'd7, 12'h300, 4, 32'hC0000000, "R4 step-after-first");
    t_burst(3'd1, 3'd0, 12'hFFE, 3, 32'hD0000000, "R2 wrap");
    t_imm();
    t_zero();
    t_bad();
    bp_on = 1'b1;
    t_burst(3'd1, 3'd3, 12'h400, 24, 32'hE0000000, "R9 stepping under stall");
    t_burst(3'd5, 3'd1, 12'h500, 12, 32'hF0000000, "R9 step-after-first under stall");
    bp_on = 1'b0;
    chk(err_flag == 1'b1, "R7 still set", 32'(err_flag), 32'd1);
    report();
    $finish;
  end
endmodule